// File: doc/BRIEF.md
# Converter Power-Down and Start-Up Sequencer

This block steps the digital side of an audio converter through power-down, start-up settling and soft reset. An active-low external power-down pin resets the block's control state asynchronously. The pin's release is synchronised by two flops. A counter then holds the internal power-down signal asserted for a settling interval of 10 ms by default. That interval is computed as the ceiling of the master-clock frequency times the interval length. Register writes are refused until the interval has elapsed.

A second level of control sits in a control register: a run bit that resets to 0. While it is 0, the converter cores stay disabled even after the internal power-down has released. Writing it to 1 enables them, and writing it back to 0 returns the cores to reset without repeating the settling wait.

The block gates the three serial-data lanes, the bit clock and the frame clock low whenever the cores are disabled. It drives the zero-detect pin low while internal power-down is asserted, and at other times drives it with a polarity chosen by a register bit.

Top module: `codec_pwr_seq`

## Requirements
- R1: While `pinPdnN` is low, and immediately when it falls, the control state takes its defaults: run bit 0, polarity bit 1, `intPdnN` 0, `wrAccept` 0, `coreEn` 0 and `ready` 0.
- R2: After `pinPdnN` rises, `intPdnN` goes high after exactly SETTLE+2 rising clock edges, with SETTLE = ceil(CLK_HZ * SETTLE_US / 1e6). The edges are counted from the first edge that sees the pin high. Two of them are for synchronisation and SETTLE are for counting.
- R3: `wrAccept` equals `intPdnN`. A write strobed while `wrAccept` is 0 changes no register.
- R4: The control register is at address CTRL_ADDR (default 0). Bit 0 is the run bit and bit 1 is the zero-detect polarity. A write takes effect at the clock edge that samples `wrEn` high. Writes to any other address change nothing.
- R5: `coreEn` and `ready` are high exactly when `intPdnN` is high and the run bit is 1.
- R6: Each bit of `sdOut`, and `bclkOut` and `lrclkOut`, equals its input while `coreEn` is high and is 0 otherwise.
- R7: `dzOut` is 0 while `intPdnN` is low. Otherwise it equals `dzIn` when the polarity bit is 1, and the inverse of `dzIn` when it is 0.
- R8: Clearing the run bit after release drops `coreEn` while `intPdnN` stays high. Setting the run bit again raises `coreEn` after that write's edge, with no new settling wait.
- R9: A low pulse on `pinPdnN` during operation restarts the whole settling interval on the next rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| pinPdnN | input | 1 | External power-down, active low, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | DATA_W | Register write data |
| sdIn | input | LANES | Serial data from the converter cores |
| bclkIn | input | 1 | Bit clock from the serial interface |
| lrclkIn | input | 1 | Frame clock from the serial interface |
| dzIn | input | 1 | Raw zero-detect flag, active high |
| intPdnN | output | 1 | Internal power-down, active low |
| wrAccept | output | 1 | High when register writes are taken |
| coreEn | output | 1 | Enable for converter cores and internal master clock |
| ready | output | 1 | Status: released and running |
| sdOut | output | LANES | Gated serial data pins |
| bclkOut | output | 1 | Gated bit clock pin |
| lrclkOut | output | 1 | Gated frame clock pin |
| dzOut | output | 1 | Zero-detect pin with polarity applied |

## Verification
The hardest situation to reach is a write that arrives during the settling window and is refused. Its effect only shows once the window has passed, because the cores stay disabled even after release. The stimulus writes the run bit mid-window and then observes `coreEn` after release. It also drops the pin asynchronously between clock edges, and checks that internal power-down falls before the next edge and that the full interval is counted again. A behavioural model tracks edges since the pin rose and is compared with every output on every cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  // control register field positions
  localparam int unsigned RUN_BIT = 0;
  localparam int unsigned POL_BIT = 1;

  // strobes from the control module to the pin datapath
  typedef struct packed {
    logic intPdnN;
    logic coreEn;
    logic dzPol;
  } pwrCtl_t;

  // ceiling of hz * us / 1e6
  function automatic int unsigned settle_cycles(longint unsigned hz, longint unsigned us);
    longint unsigned prod;
    prod = hz * us + 64'd999999;
    return 32'(prod / 64'd1000000);
  endfunction

endpackage

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned SETTLE    = 122880,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              pinPdnN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output pwrCtl_t           ctl,
  output logic              wrAccept
);

  localparam int unsigned CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE - 1);

  logic             syncA;
  logic             syncB;
  logic [CNT_W-1:0] settleCnt;
  logic             settled;
  logic             runBit;
  logic             polBit;
  logic             ctrlWrite;

  // two-flop synchroniser; pin low clears it at once
  always_ff @(posedge clk or negedge pinPdnN) begin
    if (!pinPdnN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= 1'b1;
      syncB <= syncA;
    end
  end

  // settling counter; the flag releases internal power-down
  always_ff @(posedge clk or negedge pinPdnN) begin
    if (!pinPdnN) begin
      settleCnt <= '0;
      settled   <= 1'b0;
    end else if (syncB && !settled) begin
      settleCnt <= settleCnt + 1'b1;
      if (settleCnt == LAST_CNT) settled <= 1'b1;
    end
  end

  assign wrAccept  = settled;
  assign ctrlWrite = wrEn && settled && (wrAddr == ADDR_W'(CTRL_ADDR));

  // control register
  always_ff @(posedge clk or negedge pinPdnN) begin
    if (!pinPdnN) begin
      runBit <= 1'b0;
      polBit <= 1'b1;
    end else if (ctrlWrite) begin
      runBit <= wrData[RUN_BIT];
      polBit <= wrData[POL_BIT];
    end
  end

  assign ctl.intPdnN = settled;
  assign ctl.coreEn  = settled & runBit;
  assign ctl.dzPol   = polBit;

endmodule

// File: rtl/pwr_seq_pins.sv
module pwr_seq_pins
  import pwr_seq_pkg::*;
#(
  parameter int unsigned LANES = 3
) (
  input  pwrCtl_t          ctl,
  input  logic [LANES-1:0] sdIn,
  input  logic             bclkIn,
  input  logic             lrclkIn,
  input  logic             dzIn,
  output logic [LANES-1:0] sdOut,
  output logic             bclkOut,
  output logic             lrclkOut,
  output logic             dzOut
);

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    assign sdOut[lane] = sdIn[lane] & ctl.coreEn;
  end

  assign bclkOut  = bclkIn & ctl.coreEn;
  assign lrclkOut = lrclkIn & ctl.coreEn;
  assign dzOut    = ctl.intPdnN & ~(dzIn ^ ctl.dzPol);

endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 12288000,
  parameter int unsigned SETTLE_US = 10000,
  parameter int unsigned LANES     = 3,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              pinPdnN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  sdIn,
  input  logic              bclkIn,
  input  logic              lrclkIn,
  input  logic              dzIn,
  output logic              intPdnN,
  output logic              wrAccept,
  output logic              coreEn,
  output logic              ready,
  output logic [LANES-1:0]  sdOut,
  output logic              bclkOut,
  output logic              lrclkOut,
  output logic              dzOut
);

  localparam int unsigned SETTLE = settle_cycles(CLK_HZ, SETTLE_US);

  pwrCtl_t ctl;

  pwr_seq_ctrl #(
    .SETTLE(SETTLE), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
  ) uCtrl (
    .clk(clk), .pinPdnN(pinPdnN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ctl(ctl), .wrAccept(wrAccept)
  );

  pwr_seq_pins #(.LANES(LANES)) uPins (
    .ctl(ctl), .sdIn(sdIn), .bclkIn(bclkIn), .lrclkIn(lrclkIn), .dzIn(dzIn),
    .sdOut(sdOut), .bclkOut(bclkOut), .lrclkOut(lrclkOut), .dzOut(dzOut)
  );

  assign intPdnN = ctl.intPdnN;
  assign coreEn  = ctl.coreEn;
  assign ready   = ctl.coreEn;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 12288000,
  parameter int unsigned SETTLE_US = 10000,
  parameter int unsigned LANES     = 3
) (
  input logic             clk,
  input logic             pinPdnN,
  input logic             intPdnN,
  input logic             wrAccept,
  input logic             coreEn,
  input logic             ready,
  input logic [LANES-1:0] sdOut,
  input logic             bclkOut,
  input logic             lrclkOut,
  input logic             dzOut
);

  localparam int unsigned SETTLE = settle_cycles(CLK_HZ, SETTLE_US);
  localparam int unsigned RELEASE_AT = SETTLE + 2;
  localparam int unsigned HC_W = $clog2(RELEASE_AT + 1);

  // edges seen with the pin high, saturating at the release point
  logic [HC_W-1:0] highCnt;
  always_ff @(posedge clk or negedge pinPdnN) begin
    if (!pinPdnN) highCnt <= '0;
    else if (highCnt != HC_W'(RELEASE_AT)) highCnt <= highCnt + 1'b1;
  end

  assert_release_time_R2: assert property (@(posedge clk) disable iff (!pinPdnN)
    intPdnN == (highCnt == HC_W'(RELEASE_AT)));

  assert_no_write_in_window_R3: assert property (@(posedge clk) disable iff (!pinPdnN)
    !intPdnN |-> !wrAccept);

  assert_core_needs_release_R5: assert property (@(posedge clk) disable iff (!pinPdnN)
    (coreEn || ready) |-> intPdnN);

  assert_pins_gated_R6: assert property (@(posedge clk) disable iff (!pinPdnN)
    !coreEn |-> (sdOut == '0 && !bclkOut && !lrclkOut));

  assert_release_holds_R8: assert property (@(posedge clk) disable iff (!pinPdnN)
    intPdnN |=> intPdnN);

  always @(negedge clk) begin
    if (!pinPdnN) begin
      assert_pin_low_default_R1: assert (!intPdnN && !coreEn && !ready);
    end
    if (!intPdnN) begin
      assert_dz_low_R7: assert (!dzOut);
    end
  end

endmodule

bind codec_pwr_seq pwr_seq_chk #(
  .CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US), .LANES(LANES)
) uChk (
  .clk(clk), .pinPdnN(pinPdnN), .intPdnN(intPdnN), .wrAccept(wrAccept),
  .coreEn(coreEn), .ready(ready), .sdOut(sdOut), .bclkOut(bclkOut),
  .lrclkOut(lrclkOut), .dzOut(dzOut)
);

// File: tb/tb_codec_pwr_seq.sv
`timescale 1ns/100ps
module tb_codec_pwr_seq;

  // 1.5 MHz x 15 us = 22.5 cycles, ceiling 23
  localparam int S = 23;
  localparam int REL = S + 2;

  logic       clk = 1'b0;
  logic       pinPdnN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] sdIn = '0;
  logic       bclkIn = 1'b0, lrclkIn = 1'b0, dzIn = 1'b0;
  logic       intPdnN, wrAccept, coreEn, ready, bclkOut, lrclkOut, dzOut;
  logic [2:0] sdOut;

  codec_pwr_seq #(.CLK_HZ(1500000), .SETTLE_US(15)) dut (
    .clk(clk), .pinPdnN(pinPdnN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sdIn(sdIn), .bclkIn(bclkIn), .lrclkIn(lrclkIn), .dzIn(dzIn),
    .intPdnN(intPdnN), .wrAccept(wrAccept), .coreEn(coreEn), .ready(ready),
    .sdOut(sdOut), .bclkOut(bclkOut), .lrclkOut(lrclkOut), .dzOut(dzOut)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit running = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int hiEdges = 0;
  bit mRun = 1'b0, mPol = 1'b1;
  always @(posedge clk or negedge pinPdnN) begin
    if (!pinPdnN) begin
      hiEdges = 0; mRun = 1'b0; mPol = 1'b1;
    end else if (clk) begin
      if (wrEn && hiEdges >= REL && wrAddr == 4'd0) begin
        mRun = wrData[0]; mPol = wrData[1];
      end
      if (hiEdges < REL) hiEdges++;
    end
  end

  // free-running pattern on the gated inputs
  int pat = 0;
  always @(posedge clk) begin
    #1;
    pat++;
    sdIn = pat[2:0] ^ pat[5:3];
    bclkIn = pat[0];
    lrclkIn = pat[3];
    dzIn = pat[2] ^ pat[4];
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (running) begin
      bit eRel, eCore;
      eRel = pinPdnN && hiEdges >= REL;
      eCore = eRel && mRun;
      chk(intPdnN == eRel, "R2", intPdnN, eRel);
      chk(wrAccept == eRel, "R3", wrAccept, eRel);
      chk(coreEn == eCore, "R5", coreEn, eCore);
      chk(ready == eCore, "R5", ready, eCore);
      chk(sdOut == (eCore ? sdIn : 3'b0), "R6", sdOut, eCore ? sdIn : 3'b0);
      chk({bclkOut, lrclkOut} == (eCore ? {bclkIn, lrclkIn} : 2'b00), "R6",
          {bclkOut, lrclkOut}, eCore ? {bclkIn, lrclkIn} : 2'b00);
      chk(dzOut == (eRel && (dzIn == mPol)), "R7", dzOut, eRel && (dzIn == mPol));
    end
  end

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic releaseAndCheck();
    // pin rises just after an edge; release after edge REL
    @(posedge clk); #1;
    pinPdnN = 1'b1;
    edges(REL - 1);
    @(negedge clk);
    chk(intPdnN == 1'b0, "R2", intPdnN, 0);
    @(posedge clk);
    @(negedge clk);
    chk(intPdnN == 1'b1, "R2", intPdnN, 1);
  endtask

  initial begin
    #4;
    running = 1'b1;
    edges(4);
    @(negedge clk);
    chk({intPdnN, wrAccept, coreEn, ready} == 4'b0, "R1", {intPdnN, wrAccept, coreEn, ready}, 0);
    chk(dzOut == 1'b0, "R7", dzOut, 0);

    // write during the settling window must be refused
    @(posedge clk); #1;
    pinPdnN = 1'b1;
    edges(4);
    wrEn = 1'b1; wrAddr = 4'd0; wrData = 8'h01;
    edges(1);
    wrEn = 1'b0;
    edges(REL);
    @(negedge clk);
    chk(intPdnN == 1'b1, "R2", intPdnN, 1);
    chk(coreEn == 1'b0, "R3", coreEn, 0);

    // wrong address ignored
    wr(4'd3, 8'h01);
    @(negedge clk);
    chk(coreEn == 1'b0, "R4", coreEn, 0);

    // run with polarity 1
    wr(4'd0, 8'h03);
    @(negedge clk);
    chk(coreEn == 1'b1, "R4", coreEn, 1);
    edges(10);

    // polarity 0
    wr(4'd0, 8'h01);
    @(negedge clk);
    chk(dzOut == !dzIn, "R7", dzOut, !dzIn);
    edges(8);

    // clear run: cores stop, release stays
    wr(4'd0, 8'h00);
    @(negedge clk);
    chk(coreEn == 1'b0, "R8", coreEn, 0);
    chk(intPdnN == 1'b1, "R8", intPdnN, 1);
    edges(3);
    wr(4'd0, 8'h01);
    @(negedge clk);
    chk(coreEn == 1'b1, "R8", coreEn, 1);
    edges(5);

    // asynchronous drop between edges
    @(posedge clk); #1;
    pinPdnN = 1'b0;
    #0.5;
    chk(intPdnN == 1'b0, "R9", intPdnN, 0);
    chk(coreEn == 1'b0, "R1", coreEn, 0);
    edges(3);

    // full window again; run bit back at default
    releaseAndCheck();
    chk(coreEn == 1'b0, "R1", coreEn, 0);
    wr(4'd0, 8'h03);
    @(negedge clk);
    chk(ready == 1'b1, "R5", ready, 1);
    edges(6);

    running = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule